// File: doc/BRIEF.md
# Card Clock Divider with Update Handshake

This block derives the card clock from the reference clock. A programmable even divider sets the rate, an enable bit gates the output, and a source code is passed on to a downstream clock mux. Software writes the divider, enable and source values into pending registers. None of these values reaches the clock until software issues an update-only command by setting the start bit. The block copies the pending values into the active registers at a point where the card clock is low, and then clears the start bit. This lets software see when the new settings are in effect. The command can be told to wait until the data path reports that it is no longer busy. If software writes the command register while a command is still pending, a sticky locked-error flag is raised.

The control FSM has three states. `ST_IDLE` means no command is pending. `ST_HOLD` means the command waits for `data_busy` to fall. `ST_ALIGN` means the command waits for the card clock to be low.

The transitions are:
- `ST_IDLE` goes to `ST_HOLD` on an accepted command whose wait flag is set while `data_busy` is high.
- `ST_IDLE` goes to `ST_ALIGN` on any other accepted command.
- `ST_HOLD` goes to `ST_ALIGN` when `data_busy` falls.
- `ST_ALIGN` goes to `ST_IDLE` on a cycle where the divided output is low. In that same cycle the block loads the active settings.

Top module: `card_clk_ctrl`

## Requirements
- R1: With active divider value D (1 to 2^DIV_W-1) and the clock enabled, card_clk has a period of exactly 2*D reference cycles.
- R2: With active divider value 0 and the clock enabled, card_clk follows the reference clock, with a period of one reference cycle.
- R3: With the active enable bit (offset 0x10, bit 0) at 0, card_clk stays low.
- R4: Writes to the divider (0x08), source (0x0C) and enable (0x10) registers read back at once but leave card_clk and clk_src unchanged until an update command completes.
- R5: Writing the command register (0x2C) with bit 31 (start) and bit 21 (update-only) both set makes bit 31 read 1. Bit 31 returns to 0 once the pending values are active, within 2*D+2 cycles when not held.
- R6: A command write that lacks bit 31 or bit 21 is ignored: bit 31 reads 0 and the clock is unchanged.
- R7: If bit 13 (wait-for-data) is set and data_busy is high when the command is written, bit 31 stays 1 while data_busy stays high. The update completes after data_busy falls. Without bit 13, the update completes even while data_busy is high.
- R8: Writing the command register while bit 31 reads 1 sets bit 12 of the raw status register (0x44) and leaves the pending command unchanged. Writing 1 to that bit clears it.
- R9: Active settings are loaded only in a cycle where the divided output is low, and the divider phase restarts from the low half.
- R10: clk_src presents the active source value.
- R11: Bit 9 of the status register (0x48) mirrors data_busy. Apart from bit 12, raw status bits always read 0, including after an update.
- R12: After reset all registers read 0, no command is pending, card_clk is low and clk_src is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| data_busy | input | 1 | Data path busy indication |
| card_clk | output | 1 | Generated card clock |
| clk_src | output | SRC_W | Active source select for a downstream mux |

## Verification
The bench builds the block with DIV_W=4 and SRC_W=2. This makes a sweep over every divider value, 0 through 15, affordable: for each value it measures the card clock period and compares it with 2*D reference periods, or one period for bypass. The narrow width also keeps the longest period at 30 cycles. That leaves room to test, within one short run, the pending/active split, rejected commands, the held update while data is busy, the locked error and its clear, and the enable gate.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
    localparam logic [7:0] OFF_DIV  = 8'h08;
    localparam logic [7:0] OFF_SRC  = 8'h0C;
    localparam logic [7:0] OFF_ENA  = 8'h10;
    localparam logic [7:0] OFF_CMD  = 8'h2C;
    localparam logic [7:0] OFF_RINT = 8'h44;
    localparam logic [7:0] OFF_STAT = 8'h48;

    localparam int BIT_START = 31;
    localparam int BIT_UPD   = 21;
    localparam int BIT_WAIT  = 13;
    localparam int BIT_LOCK  = 12;
    localparam int BIT_BUSY  = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_ALIGN = 2'd2
    } upd_state_t;
endpackage

// File: rtl/card_clk_regs.sv
module card_clk_regs
    import card_clk_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             data_busy,
    input  logic             div_q,
    output logic [DIV_W-1:0] act_div,
    output logic             act_en,
    output logic [SRC_W-1:0] act_src,
    output logic             load
);
    logic [DIV_W-1:0] pend_div;
    logic [SRC_W-1:0] pend_src;
    logic             pend_en;
    logic             lock_err;
    upd_state_t       state_q, state_d;
    logic             start_rd;

    wire cmd_wr  = wr_en && (addr == OFF_CMD);
    wire cmd_ok  = wdata[BIT_START] && wdata[BIT_UPD];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_wr && cmd_ok)
                    state_d = (wdata[BIT_WAIT] && data_busy) ? ST_HOLD : ST_ALIGN;
            end
            ST_HOLD: begin
                if (!data_busy) state_d = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (!div_q) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the FSM
    always_comb begin
        load     = 1'b0;
        start_rd = 1'b1;
        unique case (state_q)
            ST_IDLE:  start_rd = 1'b0;
            ST_HOLD:  load = 1'b0;
            ST_ALIGN: load = !div_q;
            default:  start_rd = 1'b0;
        endcase
    end

    // pending and active settings, locked error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_div <= '0;
            pend_src <= '0;
            pend_en  <= 1'b0;
            act_div  <= '0;
            act_src  <= '0;
            act_en   <= 1'b0;
            lock_err <= 1'b0;
        end else begin
            if (wr_en && addr == OFF_DIV) pend_div <= wdata[DIV_W-1:0];
            if (wr_en && addr == OFF_SRC) pend_src <= wdata[SRC_W-1:0];
            if (wr_en && addr == OFF_ENA) pend_en  <= wdata[0];
            if (load) begin
                act_div <= pend_div;
                act_src <= pend_src;
                act_en  <= pend_en;
            end
            if (cmd_wr && start_rd)
                lock_err <= 1'b1;
            else if (wr_en && addr == OFF_RINT && wdata[BIT_LOCK])
                lock_err <= 1'b0;
        end
    end

    // register read
    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_DIV:  rdata[DIV_W-1:0] = pend_div;
            OFF_SRC:  rdata[SRC_W-1:0] = pend_src;
            OFF_ENA:  rdata[0] = pend_en;
            OFF_CMD:  rdata[BIT_START] = start_rd;
            OFF_RINT: rdata[BIT_LOCK] = lock_err;
            OFF_STAT: rdata[BIT_BUSY] = data_busy;
            default:  rdata = '0;
        endcase
    end

    // R7
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && data_busy) |=> (state_q == ST_HOLD));

    // R8
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && state_q != ST_IDLE) |=> (lock_err && $stable(state_q) || state_q != $past(state_q)));

    // R4
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_div) && $stable(act_en) && $stable(act_src)));
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             en,
    input  logic             load,
    output logic             q
);
    logic [DIV_W-1:0] cnt;
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= 1'b0;
            cnt <= '0;
        end else if (load || !en || div == '0) begin
            q   <= 1'b0;
            cnt <= '0;
        end else if (cnt == div - ONE) begin
            q   <= ~q;
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    // R9
    restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!q && cnt == '0));

    // R3
    gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> !q);
endmodule

// File: rtl/card_clk_gate.sv
module card_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass_on,
    input  logic div_q,
    output logic card_clk
);
    logic gate_q;

    // gate changes only while the reference clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= bypass_on;
    end

    assign card_clk = (clk & gate_q) | div_q;
endmodule

// File: rtl/card_clk_ctrl.sv
module card_clk_ctrl
    import card_clk_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             data_busy,
    output logic             card_clk,
    output logic [SRC_W-1:0] clk_src
);
    logic [DIV_W-1:0] act_div;
    logic             act_en;
    logic             load;
    logic             div_q;

    card_clk_regs #(.DIV_W(DIV_W), .SRC_W(SRC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .data_busy(data_busy), .div_q(div_q),
        .act_div(act_div), .act_en(act_en), .act_src(clk_src), .load(load)
    );

    card_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div(act_div), .en(act_en),
        .load(load), .q(div_q)
    );

    card_clk_gate u_gate (
        .clk(clk), .rst_n(rst_n), .bypass_on(act_en && act_div == '0),
        .div_q(div_q), .card_clk(card_clk)
    );

    // R9
    load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !div_q);

    // R2
    bypass_div_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div == '0 && !load) |=> !div_q);
endmodule

// File: tb/tb_card_clk_ctrl.sv
module tb_card_clk_ctrl;
    localparam int DIV_W = 4;
    localparam int SRC_W = 2;
    localparam logic [31:0] CMD_UPD  = 32'h8020_0000;
    localparam logic [31:0] CMD_WAIT = 32'h8020_2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic data_busy = 1'b0;
    logic card_clk;
    logic [SRC_W-1:0] clk_src;

    int checks = 0;
    int failures = 0;
    int ecnt = 0;
    realtime t_last = 0, t_prev = 0;

    always #5 clk = ~clk;

    card_clk_ctrl #(.DIV_W(DIV_W), .SRC_W(SRC_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .data_busy(data_busy), .card_clk(card_clk), .clk_src(clk_src)
    );

    always @(posedge card_clk) begin
        t_prev = t_last;
        t_last = $realtime;
        ecnt++;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_start_clear(input string req, input int limit);
        logic [31:0] d;
        int n = 0;
        rd(8'h2C, d);
        while (d[31] && n < limit) begin
            rd(8'h2C, d);
            n++;
        end
        chk(req, d[31], 0);
    endtask

    task automatic update(input string req);
        wr(8'h2C, CMD_UPD);
        wait_start_clear(req, 40);
    endtask

    task automatic period(output longint p);
        int n = 0;
        @(negedge clk);
        ecnt = 0;
        while (ecnt < 3 && n < 200) begin
            @(negedge clk);
            n++;
        end
        p = (ecnt >= 3) ? longint'(t_last - t_prev) : -1;
    endtask

    task automatic edges_in(input int cyc, output int e);
        @(negedge clk);
        ecnt = 0;
        repeat (cyc) @(negedge clk);
        e = ecnt;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        longint p;
        int e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd(8'h08, d); chk("R12 div", d, 0);
        rd(8'h10, d); chk("R12 ena", d, 0);
        rd(8'h2C, d); chk("R12 start", d, 0);
        rd(8'h44, d); chk("R12 rint", d, 0);
        chk("R12 src", clk_src, 0);
        edges_in(40, e); chk("R12 R3 no edges", e, 0);

        // R1 R2 sweep all divider values
        wr(8'h10, 32'h1);
        for (int dv = 0; dv < 16; dv++) begin
            wr(8'h08, 32'(dv));
            rd(8'h08, d); chk("R4 readback", d, dv);
            update("R5 start clears");
            period(p);
            chk(dv == 0 ? "R2 bypass period" : "R1 period", p, dv == 0 ? 10 : 20 * dv);
        end

        // R4 pending divider has no effect before update
        wr(8'h08, 32'h3);
        period(p); chk("R4 pending no effect", p, 300);
        // R6 malformed commands ignored
        wr(8'h2C, 32'h8000_0000);
        rd(8'h2C, d); chk("R6 start only", d[31], 0);
        wr(8'h2C, 32'h0020_0000);
        rd(8'h2C, d); chk("R6 upd only", d[31], 0);
        period(p); chk("R6 clock unchanged", p, 300);
        update("R5 start clears");
        period(p); chk("R1 after pending", p, 60);

        // R3 disable
        wr(8'h10, 32'h0);
        update("R5 start clears");
        edges_in(80, e); chk("R3 disabled", e, 0);
        wr(8'h10, 32'h1);
        update("R5 start clears");

        // R7 R8 R11 wait for data
        data_busy = 1'b1;
        rd(8'h48, d); chk("R11 busy bit", d[9], 1);
        wr(8'h08, 32'h5);
        wr(8'h2C, CMD_WAIT);
        repeat (30) @(negedge clk);
        rd(8'h2C, d); chk("R7 held start", d[31], 1);
        period(p); chk("R7 old divider", p, 60);
        wr(8'h2C, CMD_UPD);
        rd(8'h44, d); chk("R8 lock set", d[12], 1);
        rd(8'h2C, d); chk("R8 still pending", d[31], 1);
        wr(8'h44, 32'h0000_1000);
        rd(8'h44, d); chk("R8 lock cleared", d, 0);
        data_busy = 1'b0;
        rd(8'h48, d); chk("R11 busy low", d[9], 0);
        wait_start_clear("R7 release", 40);
        period(p); chk("R7 new divider", p, 100);

        // R7 no wait flag while busy
        data_busy = 1'b1;
        wr(8'h08, 32'h2);
        update("R7 no wait completes");
        data_busy = 1'b0;
        period(p); chk("R7 applied", p, 40);

        // R10 source select
        wr(8'h0C, 32'h2);
        repeat (5) @(negedge clk);
        chk("R10 pending src", clk_src, 0);
        update("R5 start clears");
        chk("R10 active src", clk_src, 2);

        // R11 no other raw status bits
        rd(8'h44, d); chk("R11 rint clean", d, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule